// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept, judging only by its 48-bit destination address. The parser upstream presents the address with a one-cycle strobe. One clock later the block returns an accept flag and a code that says why the frame was kept. Software sets the filter up through a simple write-only register port. There are four exact-match address slots, a 64-entry hash table and three control bits: multicast hashing, unicast hashing and broadcast refusal.

Each slot is stored as two registers, a low word and a high halfword. The slot is armed or disarmed by whichever half was written last. Software can therefore rewrite a slot without it ever matching a half-updated address: it writes the low word first, which disarms the slot, then the high halfword, which arms it. The hash index is a 6-bit XOR fold of all 48 address bits.

Address byte 0 is the first byte on the wire and sits in `dest_addr[7:0]`. Address bit 0 is `dest_addr[0]`, and a set `dest_addr[0]` marks a group (multicast) address.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the outputs are low, every slot is disarmed, the hash table is all zero and all control bits are clear. In that state a non-broadcast address is rejected with code 0.
- R2: The result appears on `res_valid`/`res_accept`/`res_kind` in the cycle after `addr_valid`. It uses the register contents as they were in the strobe cycle, so a write in that same cycle does not affect it. When no address was strobed, the outputs are 0.
- R3: Slot s uses two register offsets. Offset 2s is the low word, holding address bytes 0..3 with byte 0 in bits 7:0; writing it disarms the slot. Offset 2s+1 holds bytes 4 and 5 in bits 15:0; writing it arms the slot. Only armed slots can match.
- R4: An address equal to an armed slot is accepted whatever the control bits say. The code is 1 + slot index, and the lowest matching slot wins. A slot match outranks all other reasons.
- R5: Hash index bit i (i = 0..5) is the XOR of every address bit n with n mod 6 = i.
- R6: Offset 8 writes hash table bits 31:0 and offset 9 writes bits 63:32. Index k selects table bit k.
- R7: A multicast, non-broadcast address with no slot match is accepted with code 6 only when the table bit is set and control bit 0 (offset 10) is set.
- R8: A unicast address with no slot match is accepted with code 7 only when the table bit is set and control bit 1 is set.
- R9: The all-ones address with no slot match is accepted with code 5 while control bit 2 is clear. It is rejected while bit 2 is set, whatever the hash table holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 4 | Register offset |
| cfg_wr_data | input | 32 | Register write data |
| addr_valid | input | 1 | Destination address strobe |
| dest_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Result strobe, one cycle after `addr_valid` |
| res_accept | output | 1 | Frame accepted |
| res_kind | output | 3 | Match code: 0 none, 1..4 slot, 5 broadcast, 6 multicast hash, 7 unicast hash |

## Verification
The assertions assume that `dest_addr` is meaningful only while `addr_valid` is high. They also assume that register offsets above 10 are never written, since such writes are simply dropped. The stimulus always drives a defined address and offsets within range, and it never leaves inputs unknown after reset. It mixes directed cases, including writes landing in the same cycle as a strobe, with a random phase that uses only legal offsets. The random phase draws addresses from the programmed slot values, from broadcast and from random values.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
   localparam int REG_DW     = 32;
   localparam int TOP_DW     = 16;
   localparam int CTRL_W     = 3;
   localparam int CTRL_MHASH = 0;
   localparam int CTRL_UHASH = 1;
   localparam int CTRL_NOBC  = 2;

   typedef enum logic [2:0] {
      KIND_NONE  = 3'd0,
      KIND_SLOT0 = 3'd1,
      KIND_SLOT1 = 3'd2,
      KIND_SLOT2 = 3'd3,
      KIND_SLOT3 = 3'd4,
      KIND_BCAST = 3'd5,
      KIND_MHASH = 3'd6,
      KIND_UHASH = 3'd7
   } kind_e;
endpackage

// File: rtl/rxaf_cfg_regs.sv
module rxaf_cfg_regs
   import rxaf_pkg::*;
#(
   parameter int N_SLOTS = 4,
   parameter int AW      = 4,
   parameter int HTAB_W  = 64
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [AW-1:0]                 wr_addr,
   input  logic [REG_DW-1:0]             wr_data,
   output logic [N_SLOTS-1:0][REG_DW-1:0] slot_lo,
   output logic [N_SLOTS-1:0][TOP_DW-1:0] slot_hi,
   output logic [N_SLOTS-1:0]            slot_act,
   output logic [HTAB_W-1:0]             htab,
   output logic [CTRL_W-1:0]             ctrl
);
   localparam int OFS_HLO  = 2 * N_SLOTS;
   localparam int OFS_HHI  = 2 * N_SLOTS + 1;
   localparam int OFS_CTRL = 2 * N_SLOTS + 2;
   localparam int HALF_W   = HTAB_W / 2;

   generate
      if (HALF_W != REG_DW) begin : g_bad_htab
         $error("hash table halves must match the register width");
      end
   endgenerate

   genvar s;
   generate
      for (s = 0; s < N_SLOTS; s++) begin : g_slot
         localparam logic [AW-1:0] OFS_LO = AW'(2 * s);
         localparam logic [AW-1:0] OFS_HI = AW'(2 * s + 1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_lo[s]  <= '0;
               slot_hi[s]  <= '0;
               slot_act[s] <= 1'b0;
            end else if (wr_en && wr_addr == OFS_LO) begin
               slot_lo[s]  <= wr_data;
               slot_act[s] <= 1'b0;
            end else if (wr_en && wr_addr == OFS_HI) begin
               slot_hi[s]  <= wr_data[TOP_DW-1:0];
               slot_act[s] <= 1'b1;
            end
         end

         p_arm_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_addr == OFS_HI |=> slot_act[s]);
         p_disarm_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_addr == OFS_LO |=> !slot_act[s]);
         p_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_addr == OFS_LO || wr_addr == OFS_HI))
            |=> $stable(slot_act[s]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         htab <= '0;
         ctrl <= '0;
      end else if (wr_en) begin
         if (wr_addr == AW'(OFS_HLO)) htab[HALF_W-1:0]      <= wr_data;
         if (wr_addr == AW'(OFS_HHI)) htab[HTAB_W-1:HALF_W] <= wr_data;
         if (wr_addr == AW'(OFS_CTRL)) ctrl                 <= wr_data[CTRL_W-1:0];
      end
   end
endmodule

// File: rtl/rxaf_hash_fold.sv
module rxaf_hash_fold #(
   parameter int ADDR_W = 48,
   parameter int IDX_W  = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);
   genvar i;
   generate
      for (i = 0; i < IDX_W; i++) begin : g_bit
         always_comb begin
            idx[i] = 1'b0;
            for (int n = i; n < ADDR_W; n += IDX_W)
               idx[i] = idx[i] ^ addr[n];
         end
      end
   endgenerate
endmodule

// File: rtl/rxaf_slot_match.sv
module rxaf_slot_match
   import rxaf_pkg::*;
#(
   parameter int N_SLOTS = 4,
   parameter int ADDR_W  = 48
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic [N_SLOTS-1:0][REG_DW-1:0] slot_lo,
   input  logic [N_SLOTS-1:0][TOP_DW-1:0] slot_hi,
   input  logic [N_SLOTS-1:0]             slot_act,
   output logic [N_SLOTS-1:0]             hit
);
   generate
      if (ADDR_W != REG_DW + TOP_DW) begin : g_bad_width
         $error("address width must equal the two slot halves");
      end
   endgenerate

   genvar s;
   generate
      for (s = 0; s < N_SLOTS; s++) begin : g_cmp
         assign hit[s] = slot_act[s] && (addr == {slot_hi[s], slot_lo[s]});
      end
   endgenerate
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxaf_pkg::*;
#(
   parameter int N_SLOTS = 4,
   parameter int ADDR_W  = 48,
   parameter int IDX_W   = 6,
   parameter int AW      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [AW-1:0]     cfg_wr_addr,
   input  logic [31:0]       cfg_wr_data,
   input  logic              addr_valid,
   input  logic [ADDR_W-1:0] dest_addr,
   output logic              res_valid,
   output logic              res_accept,
   output logic [2:0]        res_kind
);
   localparam int HTAB_W = 1 << IDX_W;
   localparam int N_REGS = 2 * N_SLOTS + 3;

   generate
      if (N_SLOTS < 1 || N_SLOTS > 4) begin : g_bad_slots
         $error("slot count must lie in 1..4");
      end
      if ((1 << AW) < N_REGS) begin : g_bad_aw
         $error("register offset too narrow");
      end
   endgenerate

   logic [N_SLOTS-1:0][REG_DW-1:0] slot_lo;
   logic [N_SLOTS-1:0][TOP_DW-1:0] slot_hi;
   logic [N_SLOTS-1:0]             slot_act;
   logic [HTAB_W-1:0]              htab;
   logic [CTRL_W-1:0]              ctrl;
   logic [N_SLOTS-1:0]             hit;
   logic [IDX_W-1:0]               hidx;

   rxaf_cfg_regs #(.N_SLOTS(N_SLOTS), .AW(AW), .HTAB_W(HTAB_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
      .wr_data(cfg_wr_data), .slot_lo(slot_lo), .slot_hi(slot_hi),
      .slot_act(slot_act), .htab(htab), .ctrl(ctrl));

   rxaf_slot_match #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W)) u_match (
      .addr(dest_addr), .slot_lo(slot_lo), .slot_hi(slot_hi),
      .slot_act(slot_act), .hit(hit));

   rxaf_hash_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
      .addr(dest_addr), .idx(hidx));

   logic  is_group, is_bcast, hash_hit, any_hit;
   kind_e kind_d;

   assign is_group = dest_addr[0];
   assign is_bcast = &dest_addr;
   assign hash_hit = htab[hidx];
   assign any_hit  = |hit;

   always_comb begin
      kind_d = KIND_NONE;
      if (any_hit) begin
         for (int s = N_SLOTS - 1; s >= 0; s--)
            if (hit[s]) kind_d = kind_e'(s + 1);
      end else if (is_bcast) begin
         if (!ctrl[CTRL_NOBC]) kind_d = KIND_BCAST;
      end else if (is_group) begin
         if (ctrl[CTRL_MHASH] && hash_hit) kind_d = KIND_MHASH;
      end else if (ctrl[CTRL_UHASH] && hash_hit) begin
         kind_d = KIND_UHASH;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_kind   <= KIND_NONE;
      end else begin
         res_valid  <= addr_valid;
         res_accept <= addr_valid && (kind_d != KIND_NONE);
         res_kind   <= addr_valid ? kind_d : KIND_NONE;
      end
   end

   p_idle_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !addr_valid |=> !res_valid && !res_accept && res_kind == 3'd0);
   p_slot_wins_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && any_hit |=> res_accept && res_kind >= 3'd1 && res_kind <= 3'd4);
   p_nobc_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && !any_hit && is_bcast && ctrl[CTRL_NOBC] |=> !res_accept);
   p_mgate_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && !any_hit && is_group && !is_bcast && !ctrl[CTRL_MHASH]
      |=> !res_accept);
   p_ugate_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && !any_hit && !is_group && !ctrl[CTRL_UHASH] |=> !res_accept);
   p_htab_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && !any_hit && !is_bcast && !htab[hidx] |=> !res_accept);
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [3:0]  cfg_wr_addr = '0;
   logic [31:0] cfg_wr_data = '0;
   logic        addr_valid = 1'b0;
   logic [47:0] dest_addr = '0;
   logic        res_valid, res_accept;
   logic [2:0]  res_kind;

   always #5 clk = ~clk;

   rx_addr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
      .cfg_wr_data(cfg_wr_data), .addr_valid(addr_valid), .dest_addr(dest_addr),
      .res_valid(res_valid), .res_accept(res_accept), .res_kind(res_kind));

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   logic [31:0] m_bot [4];
   logic [15:0] m_top [4];
   bit          m_act [4];
   logic [63:0] m_ht;
   logic [2:0]  m_ctrl;

   bit          e_v, e_acc;
   int          e_kind;
   string       e_tag;

   function automatic int ref_hash(logic [47:0] a);
      int k = 0;
      for (int n = 0; n < 48; n++) if (a[n]) k = k ^ (1 << (n % 6));
      return k;
   endfunction

   function automatic int ref_kind(bit v, logic [47:0] a);
      if (!v) return 0;
      for (int s = 0; s < 4; s++)
         if (m_act[s] && a == {m_top[s], m_bot[s]}) return s + 1;
      if (a == 48'hFFFF_FFFF_FFFF) return m_ctrl[2] ? 0 : 5;
      if (a[0]) return (m_ctrl[0] && m_ht[ref_hash(a)]) ? 6 : 0;
      return (m_ctrl[1] && m_ht[ref_hash(a)]) ? 7 : 0;
   endfunction

   task automatic check(string tag, bit ok, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      check(e_tag, res_valid == e_v, "res_valid", int'(res_valid), int'(e_v));
      check(e_tag, res_accept == e_acc, "res_accept", int'(res_accept), int'(e_acc));
      check(e_tag, int'(res_kind) == e_kind, "res_kind", int'(res_kind), e_kind);
   endtask

   // one clock: compare the previous result, predict the next one, drive inputs
   task automatic cyc(bit we, logic [3:0] wa, logic [31:0] wd,
                      bit v, logic [47:0] a, string tag);
      compare();
      e_v    = v;
      e_kind = ref_kind(v, a);
      e_acc  = (e_kind != 0);
      e_tag  = tag;
      if (we) begin
         if (wa < 8 && wa[0] == 1'b0) begin m_bot[wa/2] = wd; m_act[wa/2] = 0; end
         else if (wa < 8) begin m_top[wa/2] = wd[15:0]; m_act[wa/2] = 1; end
         else if (wa == 8) m_ht[31:0] = wd;
         else if (wa == 9) m_ht[63:32] = wd;
         else if (wa == 10) m_ctrl = wd[2:0];
      end
      cfg_wr_en = we; cfg_wr_addr = wa; cfg_wr_data = wd;
      addr_valid = v; dest_addr = a;
      @(negedge clk);
   endtask

   task automatic wr(logic [3:0] wa, logic [31:0] wd, string tag);
      cyc(1'b1, wa, wd, 1'b0, '0, tag);
   endtask

   task automatic fr(logic [47:0] a, string tag);
      cyc(1'b0, '0, '0, 1'b1, a, tag);
   endtask

   task automatic set_slot(int s, logic [47:0] a, string tag);
      wr(4'(2 * s), a[31:0], tag);
      wr(4'(2 * s + 1), {16'h0, a[47:32]}, tag);
   endtask

   function automatic logic [47:0] find_addr(logic [47:0] base, int lo, int hi);
      logic [47:0] a = base;
      for (int n = 0; n < 256; n++) begin
         a[15:8] = 8'(n);
         if (ref_hash(a) >= lo && ref_hash(a) <= hi) return a;
      end
      return base;
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         summary();
      end
   end

   initial begin
      logic [47:0] a_uni, a_b, a_mc, a_mc_hi, a_uc, a_x;
      int k;
      for (int s = 0; s < 4; s++) begin m_bot[s] = 0; m_top[s] = 0; m_act[s] = 0; end
      m_ht = '0; m_ctrl = '0;
      e_v = 0; e_acc = 0; e_kind = 0; e_tag = "R1";

      repeat (3) @(negedge clk);
      compare();                       // R1: outputs low during reset
      rst_n = 1'b1;
      @(negedge clk);

      a_uni = 48'h5A4B_3C2D_1E0E;
      fr(a_uni, "R1");                 // R1: nothing programmed, rejected
      fr(48'hFFFF_FFFF_FFFF, "R9");    // R9: broadcast accepted, code 5
      wr(4'd10, 32'h4, "R9");
      fr(48'hFFFF_FFFF_FFFF, "R9");    // R9: refused with bit 2 set
      wr(4'd10, 32'h0, "R9");

      set_slot(1, a_uni, "R3");
      fr(a_uni, "R3");                 // R3/R4: slot 1 -> code 2
      wr(4'd2, a_uni[31:0], "R3");     // low write disarms
      fr(a_uni, "R3");
      wr(4'd3, {16'h0, a_uni[47:32]}, "R3");
      fr(a_uni, "R3");
      fr(a_uni ^ 48'h1_0000_0000, "R3"); // upper byte differs

      a_b = 48'h0102_0304_0506;
      set_slot(2, a_b, "R4");
      set_slot(0, a_b, "R4");
      fr(a_b, "R4");                   // lowest slot wins -> code 1
      wr(4'd10, 32'h7, "R4");
      fr(a_b, "R4");                   // still slot, with all controls set
      set_slot(3, 48'hFFFF_FFFF_FFFF, "R4");
      fr(48'hFFFF_FFFF_FFFF, "R4");    // slot overrides broadcast refusal
      wr(4'd6, 32'h0, "R4");           // disarm slot 3
      fr(48'hFFFF_FFFF_FFFF, "R9");
      wr(4'd10, 32'h0, "R7");

      a_mc = find_addr(48'h00AA_5500_0001, 0, 31);
      k = ref_hash(a_mc);
      wr(4'd8, 32'(1) << k, "R6");
      fr(a_mc, "R7");                  // enable off: rejected
      wr(4'd10, 32'h1, "R7");
      fr(a_mc, "R7");                  // code 6
      fr(a_mc ^ 48'h10_0000_0000, "R5");
      a_mc_hi = find_addr(48'h1234_5600_0003, 32, 63);
      fr(a_mc_hi, "R6");               // top half still zero
      wr(4'd9, 32'(1) << (ref_hash(a_mc_hi) - 32), "R6");
      fr(a_mc_hi, "R6");

      a_uc = find_addr(48'h0077_6600_0002, 0, 63);
      k = ref_hash(a_uc);
      if (k < 32) wr(4'd8, 32'(1) << k, "R8");
      else wr(4'd9, 32'(1) << (k - 32), "R8");
      fr(a_uc, "R8");                  // unicast enable off
      wr(4'd10, 32'h2, "R8");
      fr(a_uc, "R8");                  // code 7
      fr(a_mc, "R7");                  // multicast enable now off

      // R2: write in the strobe cycle does not affect that result
      cyc(1'b1, 4'd10, 32'h0, 1'b1, a_uc, "R2");
      fr(a_uc, "R2");
      cyc(1'b1, 4'd7, {16'h0, a_uni[47:32]}, 1'b1, a_uni, "R2");
      fr(a_uni, "R2");

      for (int n = 0; n < 600; n++) begin
         int pick = int'($urandom_range(0, 3));
         int sl = int'($urandom_range(0, 3));
         a_x = {$urandom(), $urandom()};
         if (pick == 0) a_x = 48'hFFFF_FFFF_FFFF;
         else if (pick == 1) a_x = {m_top[sl], m_bot[sl]};
         cyc($urandom_range(0, 3) == 0, 4'($urandom_range(0, 10)), $urandom(),
             1'($urandom()), a_x, "R5");
      end
      cyc(1'b0, '0, '0, 1'b0, '0, "R2");
      compare();
      finished = 1;
      summary();
   end
endmodule